// File: doc/BRIEF.md
# Move-Programmed Adder Datapath

This block is a small processor datapath in which software never names an operation code. Each instruction is a bundle of parallel move slots. Each slot copies one value from a source to a destination. Sources are register reads, the adder's result port and a literal carried in the slot. Destinations are register writes and the two input ports of an integer adder/subtractor. A move into one of the adder's trigger ports starts an add or a subtract as a side effect. The other input comes from a retained operand register.

All slots of one instruction read the state that existed before the instruction and commit together on the same clock edge. The destination field selects its target port directly. A result can be moved straight from the adder into the adder's own inputs, or into a register, with no tag matching. Instructions arrive over a valid/ready port and are accepted in a single cycle.

Top module: `ttm_datapath`

## Requirements
- R1: While reset is held, `res_out` is 0, `conflict` is 0 and `in_ready` is 0. All registers and the operand register clear to 0. From the first clock edge after release, `in_ready` is 1.
- R2: Slot i occupies `in_instr[i*SLOT_W +: SLOT_W]`, where SLOT_W = 9 + DATA_W. The top bit is the slot-valid bit, then a 4-bit source id, then a 4-bit destination id, and the low DATA_W bits hold the literal. Source ids 0-7 read registers 0-7, id 8 reads the adder result, id 9 reads the literal, and all other ids read 0. Destination ids 0-7 write registers, id 8 writes the operand port, id 9 is the add trigger and id 10 is the subtract trigger.
- R3: A move to the add trigger makes the result operand + value, and a move to the subtract trigger makes it operand − value, both modulo 2^DATA_W.
- R4: The result appears on `res_out` on the clock edge that accepts the triggering instruction and holds until the next trigger. A move in the same instruction that reads the result receives the previous result.
- R5: The operand register keeps its value across triggers until a new operand move arrives.
- R6: When an operand move and a trigger move are in the same instruction, the operation uses the newly moved operand.
- R7: The result port can feed the operand port, a trigger port or a register directly.
- R8: The literal field can be the source of any move.
- R9: All slots read the state from before the instruction, so two registers can be exchanged in one instruction.
- R10: When two or more valid slots of one instruction target the same destination, the lowest-numbered slot wins and `conflict` becomes 1 and stays 1 until reset. The add and subtract triggers count as one destination.
- R11: An instruction presented with `in_valid` low, a slot with its valid bit clear, and a destination id of 11-15 or naming a register at or above NUM_REGS all leave every piece of state unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Instruction present |
| in_ready | output | 1 | Datapath accepts an instruction this cycle |
| in_instr | input | NUM_SLOTS*(9+DATA_W) | Bundle of move slots, slot 0 in the low bits |
| res_out | output | DATA_W | Current value of the adder result port |
| conflict | output | 1 | Sticky flag for a destination written twice in one instruction |

## Verification
The bench builds the block with three move slots, eight registers and 16-bit data. A third slot makes three-way collisions possible, and it also lets a middle slot win over a higher one, which two slots cannot show. With three slots, one instruction can also load the operand, fire a trigger and store the old result. Register contents are brought out by moving them through the adder with a zero operand, and a behavioural model of moves checks the result and the conflict flag on every cycle, both in directed sequences and in a long random run.

// File: rtl/ttm_pkg.sv
package ttm_pkg;
    localparam int ID_W = 4;
    localparam logic [ID_W-1:0] SRC_RESULT = 4'd8;
    localparam logic [ID_W-1:0] SRC_LIT    = 4'd9;
    localparam logic [ID_W-1:0] DST_OPND   = 4'd8;
    localparam logic [ID_W-1:0] DST_ADDT   = 4'd9;
    localparam logic [ID_W-1:0] DST_SUBT   = 4'd10;
endpackage

// File: rtl/ttm_move_source.sv
module ttm_move_source
    import ttm_pkg::*;
#(
    parameter int DATA_W   = 16,
    parameter int NUM_REGS = 8,
    localparam int SLOT_W  = 1 + 2*ID_W + DATA_W,
    localparam int NPORT   = NUM_REGS + 2
) (
    input  logic [SLOT_W-1:0]          slot_i,
    input  logic [NUM_REGS*DATA_W-1:0] regs_i,
    input  logic [DATA_W-1:0]          result_i,
    output logic [DATA_W-1:0]          val_o,
    output logic [NPORT-1:0]           hit_o,
    output logic                       sub_o
);
    logic              vld;
    logic [ID_W-1:0]   src;
    logic [ID_W-1:0]   dst;
    logic [DATA_W-1:0] lit;

    assign {vld, src, dst, lit} = slot_i;

    always_comb begin
        val_o = '0;
        for (int r = 0; r < NUM_REGS; r++) begin
            if (src == ID_W'(r)) val_o = regs_i[r*DATA_W +: DATA_W];
        end
        if (src == SRC_RESULT) val_o = result_i;
        if (src == SRC_LIT)    val_o = lit;
    end

    always_comb begin
        hit_o = '0;
        if (vld) begin
            for (int r = 0; r < NUM_REGS; r++) begin
                if (dst == ID_W'(r)) hit_o[r] = 1'b1;
            end
            if (dst == DST_OPND) hit_o[NUM_REGS] = 1'b1;
            if (dst == DST_ADDT || dst == DST_SUBT) hit_o[NUM_REGS+1] = 1'b1;
        end
        sub_o = (dst == DST_SUBT);
    end

    always_comb begin
        assert_single_target_R2: assert ($onehot0(hit_o));
    end
endmodule

// File: rtl/ttm_move_arbiter.sv
module ttm_move_arbiter #(
    parameter int NUM_SLOTS = 2,
    parameter int NPORT     = 10,
    parameter int DATA_W    = 16
) (
    input  logic                          accept_i,
    input  logic [NUM_SLOTS*NPORT-1:0]    hit_i,
    input  logic [NUM_SLOTS*DATA_W-1:0]   val_i,
    input  logic [NUM_SLOTS-1:0]          sub_i,
    output logic [NPORT-1:0]              we_o,
    output logic [NPORT*DATA_W-1:0]       wdata_o,
    output logic                          trig_sub_o,
    output logic                          clash_o
);
    localparam logic [NUM_SLOTS-1:0] ONE = NUM_SLOTS'(1);

    logic [NPORT*NUM_SLOTS-1:0] gnt_all;
    logic [NPORT-1:0]           multi;

    for (genvar p = 0; p < NPORT; p++) begin : g_port
        logic [NUM_SLOTS-1:0] req;
        logic [NUM_SLOTS-1:0] gnt;
        logic [DATA_W-1:0]    data;

        for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_req
            assign req[s] = accept_i & hit_i[s*NPORT + p];
        end

        // lowest-numbered requesting slot takes the port
        assign gnt = req & (~req + ONE);

        always_comb begin
            data = '0;
            for (int s = 0; s < NUM_SLOTS; s++) begin
                if (gnt[s]) data = val_i[s*DATA_W +: DATA_W];
            end
        end

        assign we_o[p]                     = |req;
        assign multi[p]                    = (req != gnt);
        assign wdata_o[p*DATA_W +: DATA_W] = data;
        assign gnt_all[p*NUM_SLOTS +: NUM_SLOTS] = gnt;

        always_comb begin
            assert_one_winner_R10: assert ($onehot0(gnt) && ((gnt != '0) == (req != '0)));
        end
    end

    always_comb begin
        trig_sub_o = 1'b0;
        for (int s = 0; s < NUM_SLOTS; s++) begin
            if (gnt_all[(NPORT-1)*NUM_SLOTS + s]) trig_sub_o = sub_i[s];
        end
    end

    assign clash_o = |multi;
endmodule

// File: rtl/ttm_add_unit.sv
module ttm_add_unit #(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              opnd_we,
    input  logic [DATA_W-1:0] opnd_wdata,
    input  logic              trig_we,
    input  logic [DATA_W-1:0] trig_wdata,
    input  logic              trig_sub,
    output logic [DATA_W-1:0] result_o
);
    typedef struct packed {
        logic [DATA_W-1:0] opnd;
        logic [DATA_W-1:0] res;
    } au_state_t;

    au_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (opnd_we) st_d.opnd = opnd_wdata;
        if (trig_we) st_d.res = trig_sub ? (st_d.opnd - trig_wdata)
                                         : (st_d.opnd + trig_wdata);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign result_o = st_q.res;

    assert_result_holds_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !trig_we |=> $stable(result_o));

    assert_operand_kept_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !opnd_we |=> $stable(st_q.opnd));

    assert_add_value_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (trig_we && !trig_sub) |=>
        result_o == $past((opnd_we ? opnd_wdata : st_q.opnd) + trig_wdata));

    assert_sub_value_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (trig_we && trig_sub) |=>
        result_o == $past((opnd_we ? opnd_wdata : st_q.opnd) - trig_wdata));
endmodule

// File: rtl/ttm_datapath.sv
module ttm_datapath
    import ttm_pkg::*;
#(
    parameter int NUM_SLOTS = 2,
    parameter int NUM_REGS  = 8,
    parameter int DATA_W    = 16,
    localparam int SLOT_W   = 1 + 2*ID_W + DATA_W,
    localparam int NPORT    = NUM_REGS + 2,
    localparam int P_OPND   = NUM_REGS,
    localparam int P_TRIG   = NUM_REGS + 1
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        in_valid,
    output logic                        in_ready,
    input  logic [NUM_SLOTS*SLOT_W-1:0] in_instr,
    output logic [DATA_W-1:0]           res_out,
    output logic                        conflict
);
    typedef struct packed {
        logic [NUM_REGS-1:0][DATA_W-1:0] regs;
        logic                            clash;
        logic                            rdy;
    } dp_state_t;

    dp_state_t st_d, st_q;

    logic                        accept;
    logic [DATA_W-1:0]           result;
    logic [NUM_SLOTS*DATA_W-1:0] slot_val;
    logic [NUM_SLOTS*NPORT-1:0]  slot_hit;
    logic [NUM_SLOTS-1:0]        slot_sub;
    logic [NPORT-1:0]            we;
    logic [NPORT*DATA_W-1:0]     wdata;
    logic                        trig_sub;
    logic                        clash;

    assign accept = in_valid & st_q.rdy;

    for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_slot
        ttm_move_source #(.DATA_W(DATA_W), .NUM_REGS(NUM_REGS)) u_src (
            .slot_i   (in_instr[s*SLOT_W +: SLOT_W]),
            .regs_i   (st_q.regs),
            .result_i (result),
            .val_o    (slot_val[s*DATA_W +: DATA_W]),
            .hit_o    (slot_hit[s*NPORT +: NPORT]),
            .sub_o    (slot_sub[s])
        );
    end

    ttm_move_arbiter #(.NUM_SLOTS(NUM_SLOTS), .NPORT(NPORT), .DATA_W(DATA_W)) u_arb (
        .accept_i   (accept),
        .hit_i      (slot_hit),
        .val_i      (slot_val),
        .sub_i      (slot_sub),
        .we_o       (we),
        .wdata_o    (wdata),
        .trig_sub_o (trig_sub),
        .clash_o    (clash)
    );

    ttm_add_unit #(.DATA_W(DATA_W)) u_add (
        .clk        (clk),
        .rst_n      (rst_n),
        .opnd_we    (we[P_OPND]),
        .opnd_wdata (wdata[P_OPND*DATA_W +: DATA_W]),
        .trig_we    (we[P_TRIG]),
        .trig_wdata (wdata[P_TRIG*DATA_W +: DATA_W]),
        .trig_sub   (trig_sub),
        .result_o   (result)
    );

    always_comb begin
        st_d     = st_q;
        st_d.rdy = 1'b1;
        for (int r = 0; r < NUM_REGS; r++) begin
            if (we[r]) st_d.regs[r] = wdata[r*DATA_W +: DATA_W];
        end
        if (clash) st_d.clash = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign in_ready = st_q.rdy;
    assign res_out  = result;
    assign conflict = st_q.clash;

    assert_clash_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
        conflict |=> conflict);

    assert_idle_regs_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !accept |=> $stable(st_q.regs));

    assert_idle_result_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !accept |=> $stable(res_out));

    assert_ready_after_reset_R1: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> in_ready);
endmodule

// File: tb/ttm_datapath_test.sv
module ttm_datapath_test;
    localparam int CLK_PERIOD = 10;
    localparam int NS   = 3;
    localparam int NR   = 8;
    localparam int DW   = 16;
    localparam int SW   = 9 + DW;
    localparam int IW   = NS * SW;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          in_valid = 1'b0;
    logic          in_ready;
    logic [IW-1:0] in_instr = '0;
    logic [DW-1:0] res_out;
    logic          conflict;

    int checks = 0;
    int fails  = 0;

    logic [DW-1:0] mregs [NR];
    logic [DW-1:0] mop  = '0;
    logic [DW-1:0] mres = '0;
    logic          mclash = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    ttm_datapath #(.NUM_SLOTS(NS), .NUM_REGS(NR), .DATA_W(DW)) uut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .in_instr(in_instr), .res_out(res_out), .conflict(conflict)
    );

    function automatic logic [SW-1:0] mv(int src, int dst, int lit);
        return {1'b1, 4'(src), 4'(dst), 16'(lit)};
    endfunction

    function automatic logic [IW-1:0] bundle(logic [SW-1:0] s0, logic [SW-1:0] s1,
                                             logic [SW-1:0] s2);
        return {s2, s1, s0};
    endfunction

    task automatic check(string tag, string what, int got, int exp);
        checks++;
        if (got != exp) begin
            fails++;
            $display("FAIL %s: %s got %0h expected %0h", tag, what, got, exp);
        end
    endtask

    task automatic model(logic [IW-1:0] ins);
        logic [DW-1:0] nr [NR];
        logic [DW-1:0] nop, tval, v;
        bit taken [10];
        bit tfire, tsub;
        nop = mop; tfire = 0; tsub = 0; tval = '0;
        for (int r = 0; r < NR; r++) nr[r] = mregs[r];
        for (int k = 0; k < 10; k++) taken[k] = 0;
        for (int s = 0; s < NS; s++) begin
            logic [SW-1:0] sl;
            int src, dst, key;
            sl  = ins[s*SW +: SW];
            src = int'(sl[SW-2 -: 4]);
            dst = int'(sl[SW-6 -: 4]);
            if (!sl[SW-1]) continue;
            if (src < NR)      v = mregs[src];
            else if (src == 8) v = mres;
            else if (src == 9) v = sl[DW-1:0];
            else               v = '0;
            if (dst < NR)                  key = dst;
            else if (dst == 8)             key = 8;
            else if (dst == 9 || dst == 10) key = 9;
            else                           key = -1;
            if (key < 0) continue;
            if (taken[key]) begin mclash = 1'b1; continue; end
            taken[key] = 1;
            if (key < NR)      nr[key] = v;
            else if (key == 8) nop = v;
            else begin tfire = 1; tval = v; tsub = (dst == 10); end
        end
        if (tfire) mres = tsub ? nop - tval : nop + tval;
        mop = nop;
        for (int r = 0; r < NR; r++) mregs[r] = nr[r];
    endtask

    // called at a falling edge; result checked at the next falling edge
    task automatic issue(logic v, logic [IW-1:0] ins, string tag);
        in_valid = v;
        in_instr = ins;
        if (v) model(ins);
        @(negedge clk);
        check(tag, "res_out", int'(res_out), int'(mres));
        check(tag, "conflict", int'(conflict), int'(mclash));
        check(tag, "in_ready", int'(in_ready), 1);
    endtask

    // bring register k out through the adder with a zero operand
    task automatic peek(int k, string tag);
        issue(1'b1, bundle(mv(9, 8, 0), mv(k, 9, 0), '0), tag);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        fails++;
        $display("FAIL watchdog: run did not finish, got timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        for (int r = 0; r < NR; r++) mregs[r] = '0;
        repeat (3) @(negedge clk);
        check("R1", "res_out in reset", int'(res_out), 0);
        check("R1", "conflict in reset", int'(conflict), 0);
        check("R1", "in_ready in reset", int'(in_ready), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1", "in_ready after release", int'(in_ready), 1);
        peek(3, "R1");

        // literals into operand and trigger
        issue(1'b1, bundle(mv(9, 8, 5), '0, '0), "R8");
        issue(1'b1, bundle(mv(9, 9, 7), '0, '0), "R3");
        issue(1'b1, bundle(mv(9, 10, 3), '0, '0), "R5");
        issue(1'b1, bundle(mv(9, 10, 9), '0, '0), "R3");
        // operand and trigger together
        issue(1'b1, bundle(mv(9, 8, 100), mv(9, 10, 1), '0), "R6");
        // previous result read in the triggering instruction
        issue(1'b1, bundle(mv(9, 9, 10), mv(8, 1, 0), '0), "R4");
        issue(1'b1, '0, "R4");
        peek(1, "R4");
        // bypass: result into both adder inputs, and into a register
        issue(1'b1, bundle(mv(9, 8, 21), mv(9, 9, 0), '0), "R7");
        issue(1'b1, bundle(mv(8, 8, 0), mv(8, 9, 0), mv(8, 6, 0)), "R7");
        peek(6, "R7");
        // parallel exchange of two registers
        issue(1'b1, bundle(mv(9, 2, 16'h1234), mv(9, 1, 16'h00ab), '0), "R9");
        issue(1'b1, bundle(mv(1, 2, 0), mv(2, 1, 0), '0), "R9");
        peek(1, "R9");
        peek(2, "R9");
        // ignored moves
        issue(1'b0, bundle(mv(9, 5, 77), mv(9, 8, 3), mv(9, 9, 4)), "R11");
        issue(1'b1, bundle(mv(9, 12, 55), mv(9, 15, 66), '0), "R11");
        issue(1'b1, bundle(mv(9, 8, 4), mv(13, 9, 0), '0), "R2");
        peek(5, "R11");
        // collisions
        issue(1'b1, bundle(mv(9, 4, 1), mv(9, 4, 2), mv(9, 4, 3)), "R10");
        peek(4, "R10");
        issue(1'b1, bundle(mv(9, 8, 50), mv(9, 9, 5), mv(9, 10, 5)), "R10");
        issue(1'b1, bundle(mv(9, 8, 8), mv(9, 8, 9), '0), "R10");

        // random traffic
        for (int i = 0; i < 400; i++) begin
            logic [IW-1:0] ins;
            for (int s = 0; s < NS; s++)
                ins[s*SW +: SW] = {1'($urandom), 4'($urandom), 4'($urandom % 12),
                                   16'($urandom)};
            issue(1'($urandom % 8 != 0), ins, "R2");
        end

        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule